// File: doc/BRIEF.md
# Second-Operand Address Former and Access Checker

This block computes the storage address of an instruction's second operand and vets it before any part of the operation is allowed to begin. The address is the sum of a base register value, an index register value and an unsigned displacement. A register field of zero selects no register, so it contributes nothing. The sum wraps at the address width.

In the same cycle the block tests the operand against three fault rules:

- the last byte of the operand must lie inside the installed memory;
- a full-word storage-to-register operand must be word aligned, and the first register of an even/odd pair operation must be even;
- when protection is enabled, the storage key of the target must equal the program's key.

The result is registered once. The control unit receives the address, an error flag, the fault type and the required action: proceed, suppress or terminate. When several faults coincide, only the highest-priority one is reported.

Top module: `oac_operand_check`

## Requirements
- R1: `rsp_ea` equals base term plus index term plus `disp`, modulo 2^24.
- R2: A register field (`base_fld` or `idx_fld`) of 0 contributes zero, whatever value is on the matching register input.
- R3: Each cycle with `req_valid` high yields exactly one response, with `rsp_valid` high in the following cycle. In reset, and in any cycle with no request before it, `rsp_valid` is 0. After reset all response outputs are 0.
- R4: If `rsp_ea + len_m1` (operand length minus one, not wrapped) is greater than or equal to `mem_size`, the fault type is 1 (addressing) and the action is 2 (terminate).
- R5: A request with `fw_load` set and `rsp_ea[1:0]` not equal to 0 gets fault type 2 (specification) and action 1 (suppress).
- R6: A request with `pair_op` set and `pair_reg` odd gets fault type 2 and action 1.
- R7: With `prot_en` set and `stor_key` different from `prog_key`, the fault type is 3 (protection) and the action is 1. With `prot_en` clear, a key mismatch causes no fault.
- R8: A protection fault on a request with `var_mm` set takes action 2 (terminate) instead of 1.
- R9: When faults coincide, the reported type follows the priority addressing, then specification, then protection.
- R10: `rsp_err` is 1 exactly when the fault type is not 0. With no fault, the type is 0 and the action is 0 (proceed). `rsp_ea` is reported in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| base_fld | input | 4 | Base register number, 0 = none |
| idx_fld | input | 4 | Index register number, 0 = none |
| base_val | input | 24 | Contents of the base register |
| idx_val | input | 24 | Contents of the index register |
| disp | input | 12 | Unsigned displacement |
| len_m1 | input | 8 | Operand length minus one, in bytes |
| mem_size | input | 25 | Installed memory size in bytes |
| fw_load | input | 1 | Full-word storage-to-register operation |
| pair_op | input | 1 | Operation acts on an even/odd register pair |
| pair_reg | input | 4 | First register of the pair |
| var_mm | input | 1 | Variable-length memory-to-memory operation |
| prot_en | input | 1 | Protection checking enabled |
| stor_key | input | 4 | Storage key of the target location |
| prog_key | input | 4 | Protection key of the program |
| rsp_valid | output | 1 | Response present |
| rsp_ea | output | 24 | Effective address |
| rsp_err | output | 1 | Any fault present |
| rsp_kind | output | 2 | Fault type: 0 none, 1 addressing, 2 specification, 3 protection |
| rsp_action | output | 2 | Action: 0 proceed, 1 suppress, 2 terminate |

## Verification
The address sum is driven with the following patterns:

- both registers present, which checks the full three-way sum;
- zero fields with non-zero register values on the inputs, which shows that the field and not the value gates each term;
- a sum that crosses 2^24, which separates wrapping from saturation.

Faults are driven one at a time at their edges: a last byte exactly at and one past the memory end, aligned and misaligned words, and even and odd pair registers. Key mismatches are driven with protection on and off, and with and without the variable-length flag. Finally, requests with two or three faults together separate the priority order from any other ordering, and a pause between requests shows that no response appears without a request.

// File: rtl/oac_pkg.sv
package oac_pkg;
  localparam int OAC_AW = 24;
  localparam int OAC_DW = 12;
  localparam int OAC_RW = 4;
  localparam int OAC_LW = 8;
  localparam int OAC_KW = 4;

  typedef enum logic [1:0] {
    FK_NONE = 2'd0,
    FK_ADDR = 2'd1,
    FK_SPEC = 2'd2,
    FK_PROT = 2'd3
  } fault_kind_e;

  typedef enum logic [1:0] {
    ACT_GO        = 2'd0,
    ACT_SUPPRESS  = 2'd1,
    ACT_TERMINATE = 2'd2
  } fault_act_e;
endpackage

// File: rtl/oac_addr_gen.sv
module oac_addr_gen #(
  parameter int AW = oac_pkg::OAC_AW,
  parameter int DW = oac_pkg::OAC_DW,
  parameter int RW = oac_pkg::OAC_RW,
  parameter int LW = oac_pkg::OAC_LW
) (
  input  logic [RW-1:0] base_fld,
  input  logic [RW-1:0] idx_fld,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] idx_val,
  input  logic [DW-1:0] disp,
  input  logic [LW-1:0] len_m1,
  output logic [AW-1:0] ea,
  output logic [AW:0]   last_addr
);
  // A register field of zero selects nothing.
  function automatic logic [AW-1:0] reg_term(input logic [RW-1:0] fld,
                                             input logic [AW-1:0] val);
    return (fld == '0) ? '0 : val;
  endfunction

  // Three-way sum, wrapped to the address width.
  function automatic logic [AW-1:0] wrap_sum(input logic [AW-1:0] a,
                                             input logic [AW-1:0] b,
                                             input logic [DW-1:0] d);
    logic [AW-1:0] dz;
    dz = {{(AW-DW){1'b0}}, d};
    return a + b + dz;
  endfunction

  // Address of the last operand byte, kept one bit wider so it is never wrapped.
  function automatic logic [AW:0] tail_addr(input logic [AW-1:0] a,
                                            input logic [LW-1:0] l);
    return {1'b0, a} + {{(AW+1-LW){1'b0}}, l};
  endfunction

  logic [AW-1:0] base_term;
  logic [AW-1:0] idx_term;

  assign base_term = reg_term(base_fld, base_val);
  assign idx_term  = reg_term(idx_fld, idx_val);
  assign ea        = wrap_sum(base_term, idx_term, disp);
  assign last_addr = tail_addr(ea, len_m1);
endmodule

// File: rtl/oac_fault_eval.sv
module oac_fault_eval
  import oac_pkg::*;
#(
  parameter int AW = OAC_AW,
  parameter int RW = OAC_RW,
  parameter int KW = OAC_KW
) (
  input  logic [AW-1:0] ea,
  input  logic [AW:0]   last_addr,
  input  logic [AW:0]   mem_size,
  input  logic          fw_load,
  input  logic          pair_op,
  input  logic [RW-1:0] pair_reg,
  input  logic          var_mm,
  input  logic          prot_en,
  input  logic [KW-1:0] stor_key,
  input  logic [KW-1:0] prog_key,
  output logic          addr_fault,
  output logic          spec_fault,
  output logic          prot_fault,
  output fault_kind_e   kind,
  output fault_act_e    action
);
  logic misalign;
  logic odd_pair;

  assign addr_fault = (last_addr >= mem_size);
  assign misalign   = fw_load & (ea[1:0] != 2'b00);
  assign odd_pair   = pair_op & pair_reg[0];
  assign spec_fault = misalign | odd_pair;
  assign prot_fault = prot_en & (stor_key != prog_key);

  // The fixed priority picks one fault; each type maps to its own action.
  always_comb begin
    kind   = FK_NONE;
    action = ACT_GO;
    if (addr_fault) begin
      kind   = FK_ADDR;
      action = ACT_TERMINATE;
    end else if (spec_fault) begin
      kind   = FK_SPEC;
      action = ACT_SUPPRESS;
    end else if (prot_fault) begin
      kind   = FK_PROT;
      action = var_mm ? ACT_TERMINATE : ACT_SUPPRESS;
    end
  end
endmodule

// File: rtl/oac_operand_check.sv
module oac_operand_check
  import oac_pkg::*;
#(
  parameter int AW = OAC_AW,
  parameter int DW = OAC_DW,
  parameter int RW = OAC_RW,
  parameter int LW = OAC_LW,
  parameter int KW = OAC_KW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [RW-1:0] base_fld,
  input  logic [RW-1:0] idx_fld,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] idx_val,
  input  logic [DW-1:0] disp,
  input  logic [LW-1:0] len_m1,
  input  logic [AW:0]   mem_size,
  input  logic          fw_load,
  input  logic          pair_op,
  input  logic [RW-1:0] pair_reg,
  input  logic          var_mm,
  input  logic          prot_en,
  input  logic [KW-1:0] stor_key,
  input  logic [KW-1:0] prog_key,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_ea,
  output logic          rsp_err,
  output logic [1:0]    rsp_kind,
  output logic [1:0]    rsp_action
);
  logic [AW-1:0] ea_c;
  logic [AW:0]   last_c;
  logic          addr_fault;
  logic          spec_fault;
  logic          prot_fault;
  fault_kind_e   kind_c;
  fault_act_e    act_c;

  oac_addr_gen #(.AW(AW), .DW(DW), .RW(RW), .LW(LW)) u_agen (
    .base_fld (base_fld),
    .idx_fld  (idx_fld),
    .base_val (base_val),
    .idx_val  (idx_val),
    .disp     (disp),
    .len_m1   (len_m1),
    .ea       (ea_c),
    .last_addr(last_c)
  );

  oac_fault_eval #(.AW(AW), .RW(RW), .KW(KW)) u_feval (
    .ea        (ea_c),
    .last_addr (last_c),
    .mem_size  (mem_size),
    .fw_load   (fw_load),
    .pair_op   (pair_op),
    .pair_reg  (pair_reg),
    .var_mm    (var_mm),
    .prot_en   (prot_en),
    .stor_key  (stor_key),
    .prog_key  (prog_key),
    .addr_fault(addr_fault),
    .spec_fault(spec_fault),
    .prot_fault(prot_fault),
    .kind      (kind_c),
    .action    (act_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_ea     <= '0;
      rsp_err    <= 1'b0;
      rsp_kind   <= 2'd0;
      rsp_action <= 2'd0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_ea     <= ea_c;
        rsp_err    <= (kind_c != FK_NONE);
        rsp_kind   <= kind_c;
        rsp_action <= act_c;
      end
    end
  end
endmodule

// File: rtl/oac_operand_check_sva.sv
module oac_operand_check_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       var_mm,
  input logic       prot_en,
  input logic       addr_fault,
  input logic       spec_fault,
  input logic       prot_fault,
  input logic       rsp_valid,
  input logic       rsp_err,
  input logic [1:0] rsp_kind,
  input logic [1:0] rsp_action
);
  p_resp_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_addr_term_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && addr_fault) |=> (rsp_kind == 2'd1 && rsp_action == 2'd2));

  // Covers R5 and R6: both feed the specification fault.
  p_spec_suppress_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !addr_fault && spec_fault) |=> (rsp_kind == 2'd2 && rsp_action == 2'd1));

  p_prot_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !prot_en) |=> (rsp_kind != 2'd3));

  p_prot_var_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !addr_fault && !spec_fault && prot_fault && var_mm) |=> (rsp_action == 2'd2));

  p_priority_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && addr_fault && spec_fault) |=> (rsp_kind == 2'd1));

  p_err_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_err == (rsp_kind != 2'd0)));

  p_go_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == 2'd0) |-> (rsp_action == 2'd0));
endmodule

bind oac_operand_check oac_operand_check_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .var_mm    (var_mm),
  .prot_en   (prot_en),
  .addr_fault(addr_fault),
  .spec_fault(spec_fault),
  .prot_fault(prot_fault),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_kind  (rsp_kind),
  .rsp_action(rsp_action)
);

// File: tb/tb_oac_operand_check.sv
`timescale 1ns/1ps
module tb_oac_operand_check;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  base_fld = '0, idx_fld = '0, pair_reg = '0, stor_key = '0, prog_key = '0;
  logic [23:0] base_val = '0, idx_val = '0;
  logic [11:0] disp = '0;
  logic [7:0]  len_m1 = '0;
  logic [24:0] mem_size = 25'h100000;
  logic        fw_load = 1'b0, pair_op = 1'b0, var_mm = 1'b0, prot_en = 1'b0;
  logic        rsp_valid, rsp_err;
  logic [23:0] rsp_ea;
  logic [1:0]  rsp_kind, rsp_action;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [23:0] ea;
    logic [1:0]  kind;
    logic [1:0]  act;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  oac_operand_check dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .base_fld(base_fld), .idx_fld(idx_fld), .base_val(base_val), .idx_val(idx_val),
    .disp(disp), .len_m1(len_m1), .mem_size(mem_size),
    .fw_load(fw_load), .pair_op(pair_op), .pair_reg(pair_reg), .var_mm(var_mm),
    .prot_en(prot_en), .stor_key(stor_key), .prog_key(prog_key),
    .rsp_valid(rsp_valid), .rsp_ea(rsp_ea), .rsp_err(rsp_err),
    .rsp_kind(rsp_kind), .rsp_action(rsp_action)
  );

  // Driver: applies one request at a falling edge and queues the expected result.
  task automatic send(input string tag, input logic [3:0] bf, input logic [23:0] bv,
                      input logic [3:0] xf, input logic [23:0] xv, input logic [11:0] d,
                      input logic [7:0] lm1, input logic fw, input logic pr,
                      input logic [3:0] r1, input logic vm, input logic pe,
                      input logic [3:0] sk, input logic [3:0] pk);
    exp_t e;
    longint unsigned sum;
    longint unsigned tail;
    @(negedge clk);
    base_fld = bf; base_val = bv; idx_fld = xf; idx_val = xv; disp = d;
    len_m1 = lm1; fw_load = fw; pair_op = pr; pair_reg = r1; var_mm = vm;
    prot_en = pe; stor_key = sk; prog_key = pk; req_valid = 1'b1;
    sum = (bf != 0 ? longint'(bv) : 0) + (xf != 0 ? longint'(xv) : 0) + longint'(d);
    sum = sum % (64'd1 << 24);
    tail = sum + longint'(lm1);
    e.ea = sum[23:0];
    e.tag = tag;
    if (tail >= longint'(mem_size)) begin
      e.kind = 2'd1; e.act = 2'd2;
    end else if ((fw && (sum % 4 != 0)) || (pr && (r1 % 2 == 1))) begin
      e.kind = 2'd2; e.act = 2'd1;
    end else if (pe && sk != pk) begin
      e.kind = 2'd3; e.act = vm ? 2'd2 : 2'd1;
    end else begin
      e.kind = 2'd0; e.act = 2'd0;
    end
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // Monitor: compares each response with the head of the queue.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_valid) begin
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R3: response with no request pending, ea=%h exp none", rsp_ea);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (rsp_ea !== e.ea || rsp_kind !== e.kind || rsp_action !== e.act ||
              rsp_err !== (e.kind != 2'd0)) begin
            errors++;
            $display("FAIL %s: ea=%h kind=%0d act=%0d err=%0d exp ea=%h kind=%0d act=%0d err=%0d",
                     e.tag, rsp_ea, rsp_kind, rsp_action, rsp_err, e.ea, e.kind, e.act,
                     (e.kind != 2'd0));
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, got running exp finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_ea !== '0 || rsp_err !== 1'b0 ||
        rsp_kind !== 2'd0 || rsp_action !== 2'd0) begin
      errors++;
      $display("FAIL R3: reset outputs v=%0d ea=%h err=%0d k=%0d a=%0d exp all 0",
               rsp_valid, rsp_ea, rsp_err, rsp_kind, rsp_action);
    end
    rst_n = 1'b1;
    idle(2);
    // R1: base, index and displacement summed
    send("R1", 4'd3, 24'h001000, 4'd5, 24'h000200, 12'h034, 8'd0, 0,0,4'd0,0,0,4'd0,4'd0);
    // R2: zero fields ignore nonzero register values
    send("R2", 4'd0, 24'h0ABCDE, 4'd0, 24'h012345, 12'hFF8, 8'd0, 0,0,4'd0,0,0,4'd0,4'd0);
    send("R2", 4'd7, 24'h000400, 4'd0, 24'h055555, 12'h004, 8'd3, 0,0,4'd0,0,0,4'd0,4'd0);
    // R1: wrap modulo 2^24, memory covers all
    mem_size = 25'h1000000;
    send("R1", 4'd1, 24'hFFFF00, 4'd2, 24'h000100, 12'h010, 8'd0, 0,0,4'd0,0,0,4'd0,4'd0);
    mem_size = 25'h100000;
    // R4: last byte exactly at the end, then one past
    send("R4", 4'd1, 24'h0FFFF0, 4'd0, 24'h0, 12'h000, 8'd15, 0,0,4'd0,0,0,4'd0,4'd0);
    send("R4", 4'd1, 24'h0FFFF0, 4'd0, 24'h0, 12'h001, 8'd15, 0,0,4'd0,0,0,4'd0,4'd0);
    // R5: aligned and misaligned full word
    send("R5", 4'd2, 24'h000100, 4'd0, 24'h0, 12'h004, 8'd3, 1,0,4'd0,0,0,4'd0,4'd0);
    send("R5", 4'd2, 24'h000100, 4'd0, 24'h0, 12'h006, 8'd3, 1,0,4'd0,0,0,4'd0,4'd0);
    // R6: even and odd pair register
    send("R6", 4'd2, 24'h000100, 4'd0, 24'h0, 12'h000, 8'd0, 0,1,4'd4,0,0,4'd0,4'd0);
    send("R6", 4'd2, 24'h000100, 4'd0, 24'h0, 12'h000, 8'd0, 0,1,4'd5,0,0,4'd0,4'd0);
    // R7: key mismatch with protection on, off; matching keys
    send("R7", 4'd2, 24'h000200, 4'd0, 24'h0, 12'h000, 8'd0, 0,0,4'd0,0,1,4'd3,4'd6);
    send("R7", 4'd2, 24'h000200, 4'd0, 24'h0, 12'h000, 8'd0, 0,0,4'd0,0,0,4'd3,4'd6);
    send("R7", 4'd2, 24'h000200, 4'd0, 24'h0, 12'h000, 8'd0, 0,0,4'd0,0,1,4'd6,4'd6);
    // R8: variable-length memory-to-memory mismatch terminates
    send("R8", 4'd2, 24'h000200, 4'd0, 24'h0, 12'h000, 8'd9, 0,0,4'd0,1,1,4'd1,4'd2);
    idle(3);
    // R9: combined faults
    send("R9", 4'd1, 24'h0FFFFE, 4'd0, 24'h0, 12'h000, 8'd3, 1,1,4'd3,0,1,4'd1,4'd2);
    send("R9", 4'd1, 24'h000002, 4'd0, 24'h0, 12'h000, 8'd3, 1,0,4'd0,1,1,4'd1,4'd2);
    send("R9", 4'd1, 24'h000010, 4'd0, 24'h0, 12'h000, 8'd3, 0,1,4'd7,1,1,4'd1,4'd2);
    // R10: clean request after faults
    send("R10", 4'd9, 24'h000800, 4'd10, 24'h000040, 12'h008, 8'd7, 1,1,4'd2,1,1,4'd5,4'd5);
    idle(4);
    checks++;
    if (sb.size() != 0 || rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R3: pending=%0d rsp_valid=%0d exp 0 and 0", sb.size(), rsp_valid);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule